// File: doc/BRIEF.md
# Pipelined Radix-4 Booth Signed Multiplier

This block multiplies two signed two's-complement operands of W bits and returns the full 2W-bit signed product. The multiplier operand is recoded into W/2 radix-4 digits. Each digit picks one partial product from 0, +A, +2A, −A or −2A. The rows are summed with a single constant, and the result leaves the block two clock edges after the operands enter.

For a negative digit, the row holds the bitwise inverse of the magnitude. The "+1" that completes the negation is placed in a free low bit of the next row, so no extra row is added to carry those bits. The top row has no row above it, so its selector forms the full negation itself.

Each row is sign-extended by inverting its sign bit. One precomputed constant, summed with the rows, cancels the offsets this introduces. Stage one registers the aligned rows. Stage two sums them and registers the product.

Top module: `booth_r4_mul`

## Requirements
- R1: When `in_vld` is high, the `prod_o` value delivered with the matching `out_vld` equals the signed product of `a_i` and `b_i`, both read as W-bit two's-complement numbers, for any operand pair.
- R2: Digit i is formed from multiplier bits 2i+1, 2i and 2i−1, with bit −1 taken as 0. The encoding is 000 or 111 gives 0; 001 or 010 gives +A; 011 gives +2A; 100 gives −2A; 101 or 110 gives −A. Alternating-bit multipliers (0x5555, 0xAAAA), which use several of these digits, produce exact products.
- R3: The most negative operand −2^(W−1) is handled exactly. Times itself the product is +2^(2W−2). Times −1 the product is +2^(W−1). Times the most positive operand the product is −2^(2W−2)+2^(W−1).
- R4: Multiplying by 0 gives 0. Multiplying by −1 gives the negated other operand, sign-extended to 2W bits.
- R5: `out_vld` is high in exactly those cycles that follow, by two rising clock edges, a cycle with `in_vld` high. Back-to-back inputs produce back-to-back results.
- R6: On cycles where no new result is delivered, `prod_o` keeps its previous value. Operands applied with `in_vld` low do not change it.
- R7: While `rst_n` is low, `out_vld` and `prod_o` are 0, and any result still in flight is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Operands on `a_i`/`b_i` are valid this cycle |
| a_i | input | W | Multiplicand, signed two's complement |
| b_i | input | W | Multiplier (Booth-recoded), signed two's complement |
| out_vld | output | 1 | `prod_o` carries a new result this cycle |
| prod_o | output | 2W | Signed product |

## Verification
The hardest case to reach is a −2A digit combined with a most-negative multiplicand. There, the inverted magnitude of the lower rows cannot be represented until the deferred +1 in the row above it completes it. In the top row, the selector must form a full negation of +2^W. The stimulus reaches this with multiplier patterns whose upper groups read 100, such as 0x8000, applied to 0x8000 and 0x7FFF multiplicands. It also uses alternating-bit multipliers, so that every row carries or absorbs a deferred increment. A long stream of random operands with random gaps in `in_vld` then checks the valid alignment and the hold behaviour between results.

// File: rtl/booth_pkg.sv
package booth_pkg;
  // One radix-4 Booth digit: magnitude select (one-hot or none) and sign.
  typedef struct packed {
    logic one;  // select |A|
    logic two;  // select |2A|
    logic neg;  // negate the selection
  } bdig_t;
endpackage

// File: rtl/booth_enc.sv
module booth_enc
  import booth_pkg::*;
(
  input  logic [2:0] trip,   // {b[2i+1], b[2i], b[2i-1]}
  output bdig_t      dig
);
  always_comb begin
    dig.one = trip[0] ^ trip[1];
    dig.two = (trip[2] & ~trip[1] & ~trip[0]) | (~trip[2] & trip[1] & trip[0]);
    dig.neg = trip[2] & ~(trip[1] & trip[0]);
  end
endmodule

// File: rtl/booth_sel.sv
module booth_sel
  import booth_pkg::*;
#(
  parameter int W    = 16,
  parameter bit LAST = 1'b0
) (
  input  logic [W-1:0] a,
  input  bdig_t        dig,
  output logic [W+1:0] row    // sign bit already inverted
);
  localparam int RW = W + 2;

  logic [RW-1:0] mag;
  logic [RW-1:0] pv;

  always_comb begin
    if (dig.one)      mag = {{2{a[W-1]}}, a};
    else if (dig.two) mag = {a[W-1], a, 1'b0};
    else              mag = '0;
  end

  generate
    if (LAST) begin : g_full_neg
      // Top row: no row above it to absorb the increment.
      always_comb pv = dig.neg ? (~mag + RW'(1)) : mag;
    end else begin : g_ones_neg
      // Increment is deferred into the next row's free low bit.
      always_comb pv = dig.neg ? ~mag : mag;
    end
  endgenerate

  assign row = {~pv[RW-1], pv[RW-2:0]};
endmodule

// File: rtl/booth_sum.sv
module booth_sum #(
  parameter int W    = 16,
  parameter int ROWS = W / 2
) (
  input  logic [ROWS-1:0][2*W-1:0] rows,
  output logic [2*W-1:0]           sum
);
  localparam int P = 2 * W;

  // Cancels the +2^(W+1) offset that the inverted sign bit adds to each row.
  function automatic logic [P-1:0] sign_fix();
    logic [P-1:0] k;
    k = '0;
    for (int i = 0; i < ROWS; i++) k = k - (P'(1) << (W + 1 + 2 * i));
    return k;
  endfunction

  localparam logic [P-1:0] KFIX = sign_fix();

  always_comb begin
    sum = KFIX;
    for (int i = 0; i < ROWS; i++) sum = sum + rows[i];
  end
endmodule

// File: rtl/booth_r4_mul.sv
module booth_r4_mul
  import booth_pkg::*;
#(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_vld,
  input  logic [W-1:0]   a_i,
  input  logic [W-1:0]   b_i,
  output logic           out_vld,
  output logic [2*W-1:0] prod_o
);
  localparam int P    = 2 * W;
  localparam int ROWS = W / 2;
  localparam int RW   = W + 2;

  logic [W:0]               bx;
  bdig_t                    dig   [ROWS];
  logic [RW-1:0]            rowv  [ROWS];
  logic [ROWS-1:0][P-1:0]   pos_d;
  logic [ROWS-1:0][P-1:0]   s1_q, s1_n;
  logic                     v1_q, v1_n, vo_q, vo_n;
  logic [P-1:0]             sum, prod_q, prod_n;

  assign bx = {b_i, 1'b0};

  generate
    for (genvar g = 0; g < ROWS; g++) begin : g_row
      booth_enc u_enc (.trip(bx[2*g+2:2*g]), .dig(dig[g]));
      booth_sel #(.W(W), .LAST(g == ROWS - 1)) u_sel (
        .a(a_i), .dig(dig[g]), .row(rowv[g]));
      if (g == 0) begin : g_first
        assign pos_d[g] = P'(rowv[g]);
      end else begin : g_merge
        // previous row's deferred +1 sits two bits under this row's LSB
        assign pos_d[g] = (P'(rowv[g]) << (2 * g)) | (P'(dig[g-1].neg) << (2 * g - 2));
      end

      // R2: a digit never selects both magnitudes
      a_r2_digit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |-> $onehot0({dig[g].one, dig[g].two}));
    end
  endgenerate

  booth_sum #(.W(W), .ROWS(ROWS)) u_sum (.rows(s1_q), .sum(sum));

  always_comb begin
    v1_n   = in_vld;
    s1_n   = in_vld ? pos_d : s1_q;
    vo_n   = v1_q;
    prod_n = v1_q ? sum : prod_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q   <= 1'b0;
      s1_q   <= '0;
      vo_q   <= 1'b0;
      prod_q <= '0;
    end else begin
      v1_q   <= v1_n;
      s1_q   <= s1_n;
      vo_q   <= vo_n;
      prod_q <= prod_n;
    end
  end

  assign out_vld = vo_q;
  assign prod_o  = prod_q;

  a_r5_stage1: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> v1_q);
  a_r5_stage2: assert property (@(posedge clk) disable iff (!rst_n)
    v1_q |=> out_vld);
  a_r5_bubble: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_q |=> !out_vld);
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_q |=> $stable(prod_o));
endmodule

// File: tb/sim_booth_r4_mul.sv
module sim_booth_r4_mul;
  localparam int W = 16;
  localparam int P = 32;
  localparam int NV = 15;

  // {a, b, expected product}
  localparam logic [63:0] VEC [NV] = '{
    {16'h8000, 16'h8000, 32'h40000000},
    {16'h8000, 16'hFFFF, 32'h00008000},
    {16'hFFFF, 16'h8000, 32'h00008000},
    {16'h7FFF, 16'h7FFF, 32'h3FFF0001},
    {16'h8000, 16'h7FFF, 32'hC0008000},
    {16'h7FFF, 16'h8000, 32'hC0008000},
    {16'hFFFF, 16'hFFFF, 32'h00000001},
    {16'h0000, 16'h8000, 32'h00000000},
    {16'h3039, 16'h0000, 32'h00000000},
    {16'hFFFF, 16'h04D2, 32'hFFFFFB2E},
    {16'h0003, 16'hFFFB, 32'hFFFFFFF1},
    {16'hAAAA, 16'h0002, 32'hFFFF5554},
    {16'h0002, 16'h0003, 32'h00000006},
    {16'h0007, 16'h5555, 32'h00025553},
    {16'h0007, 16'hAAAA, 32'hFFFDAAA6}
  };

  logic clk = 1'b0;
  logic rst_n, in_vld;
  logic [W-1:0] a_i, b_i;
  logic out_vld;
  logic [P-1:0] prod_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic pv [2];
  logic [P-1:0] pe [2];
  string pt [2];
  logic [P-1:0] held;

  always #5 clk = ~clk;

  booth_r4_mul #(.W(W)) u0 (
    .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .a_i(a_i), .b_i(b_i),
    .out_vld(out_vld), .prod_o(prod_o));

  task automatic chk(input bit ok, input string tag, input logic [P-1:0] act, input logic [P-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_pipe();
    pv[0] = 1'b0; pv[1] = 1'b0; pe[0] = '0; pe[1] = '0; pt[0] = "R6"; pt[1] = "R6";
  endtask

  // One cycle: check what was driven two negedges ago, then drive new operands.
  task automatic step(input logic v, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [P-1:0] exp, input string tag);
    @(negedge clk);
    chk(out_vld === pv[1], "R5 out_vld", P'(out_vld), P'(pv[1]));
    if (pv[1]) begin
      chk(prod_o === pe[1], pt[1], prod_o, pe[1]);
      held = pe[1];
    end else begin
      chk(prod_o === held, "R6 hold", prod_o, held);
    end
    pv[1] = pv[0]; pe[1] = pe[0]; pt[1] = pt[0];
    pv[0] = v;     pe[0] = exp;   pt[0] = tag;
    in_vld = v; a_i = a; b_i = b;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_vld = 1'b0; a_i = '0; b_i = '0;
    held = '0;
    clear_pipe();
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_vld === 1'b0, "R7 reset vld", P'(out_vld), '0);
    chk(prod_o === '0, "R7 reset prod", prod_o, '0);
    rst_n = 1'b1;

    // table, streamed back to back
    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = (i < 6) ? "R3" : (i < 10) ? "R4" : (i >= 13) ? "R2" : "R1";
      step(1'b1, VEC[i][63:48], VEC[i][47:32], VEC[i][31:0], tg);
    end
    // idle with changing operands: product must hold (R6)
    for (int i = 0; i < 4; i++) step(1'b0, 16'h1234 + 16'(i), 16'hBEEF, '0, "R6");

    // random operands with random gaps (R1, R5)
    for (int i = 0; i < 400; i++) begin
      logic [W-1:0] ra, rb;
      logic rv;
      ra = W'($urandom); rb = W'($urandom); rv = 1'($urandom);
      step(rv, ra, rb, P'($signed(ra) * $signed(rb)), "R1");
    end
    for (int i = 0; i < 3; i++) step(1'b0, 16'h5A5A, 16'hA5A5, '0, "R6");

    // reset with results in flight (R7)
    step(1'b1, 16'h7FFF, 16'h8000, 32'hC0008000, "R7");
    step(1'b1, 16'h0003, 16'h0003, 32'h00000009, "R7");
    #1 rst_n = 1'b0;
    #1;
    chk(out_vld === 1'b0, "R7 async vld", P'(out_vld), '0);
    chk(prod_o === '0, "R7 async prod", prod_o, '0);
    in_vld = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(out_vld === 1'b0, "R7 flushed vld", P'(out_vld), '0);
    rst_n = 1'b1;
    held = '0;
    clear_pipe();
    for (int i = 0; i < 3; i++) step(1'b0, '0, '0, '0, "R7");
    step(1'b1, 16'h8000, 16'h8000, 32'h40000000, "R3");
    for (int i = 0; i < 3; i++) step(1'b0, 16'hFFFF, 16'hFFFF, '0, "R6");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule